// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous static RAM whose write path is delayed to match its read path. A command is sampled on an active clock edge. Write data for that command is taken from the data-in bus two active edges later. Read data for a read command is loaded onto the data-out bus at the same relative edge. Because both directions use the same two-cycle slot, any order of reads and writes keeps the data bus busy on every cycle, with no idle turnaround cycles between them.

A host starts an operation by presenting an address, a read/write select and per-byte write enables while all three chip enables are active. It can then continue with an advance input that replays the previous operation at addresses produced by an internal two-bit burst counter, in linear or interleaved order. A clock-enable input freezes the whole block for one cycle. An output-enable input gates only the valid flag of the data-out bus, which models tri-state drive. The word is built from a parameterized number of byte lanes of 8 or 9 bits, so a 32-bit or 36-bit word is one parameter choice.

Top module: `ntd_sram`

## Requirements
- R1: While `rst` is high at a clock edge, `dout_en` is low after that edge. Every pipeline slot is then empty.
- R2: On an active edge with `adv` low and all chip enables active, the block accepts a write if `we_n` is 0 and a read if `we_n` is 1. The address and `bwe_n` are taken on that same edge.
- R3: The write data for a write command is sampled from `din` on the second active edge after the command edge. Values on `din` at other edges have no effect.
- R4: Read data for a read command is on `dout` after the second active edge following the command edge. `dout_en` is high at that point if `oe_n` is low.
- R5: `bwe_n` is active low with one bit per byte lane: bit g covers `din[g*LANE_W +: LANE_W]`. Lanes whose bit is 1 keep their old contents.
- R6: A command edge with `adv` low and any chip enable inactive (`ce_a_n`=1, `ce_b`=0 or `ce_c_n`=1) deselects the block. `dout_en` is low after the second active edge that follows. Reads and writes already accepted still complete.
- R7: While `adv` is 1, `addr`, `we_n` and the chip enables are ignored. The previous operation type is repeated, including deselect, at the next burst address. Address bits above bit 1 stay at the burst start address.
- R8: With `burst_ilv`=0, the k-th advance after a start address s uses low address bits (s[1:0]+k) mod 4.
- R9: With `burst_ilv`=1, the k-th advance after a start address s uses low address bits s[1:0] XOR k.
- R10: An edge with `cke_n`=1 changes nothing. The pipeline, the burst counter, the memory, `dout` and the valid state all hold, and `din` is not sampled.
- R11: `oe_n`=1 forces `dout_en` low. It has no effect on reads, writes or the value on `dout`.
- R12: A read issued right after a write to the same address returns the newly written word, with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 selects write, 1 selects read |
| adv | input | 1 | 1 continues the current burst |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| bwe_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, two active cycles after its command |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Data-out bus driven (low means high impedance) |

## Verification
The assertions check four things on every cycle. Reset clears the valid flag. A read command leads to a driven bus, and a deselect to an undriven one, exactly two active edges later. An advance keeps the upper address bits of the burst start. A stalled edge leaves the output data and valid state unchanged. The values themselves can only be shown by the bench scenarios. These cover byte-lane merging, the linear and interleaved burst orders, write data being taken from the correct slot even across stalls, a read that follows a write to the same address, and output enable hiding a read that still completes.

// File: rtl/ntd_sram_pkg.sv
package ntd_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Number of address bits the burst counter walks through.
    localparam int BURST_BITS = 2;

    // Low address bits for step k of a burst that started at 'start'.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  interleaved
    );
        return interleaved ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/ntd_burst_ctr.sv
module ntd_burst_ctr
    import ntd_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          adv,
    input  logic          ilv,
    input  logic [AW-1:0] ext_addr,
    input  op_e           ext_op,
    output logic [AW-1:0] cmd_addr,
    output op_e           cmd_op
);
    logic [AW-1:0]         base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] cnt_nx;
    op_e                   kind_q;

    assign cnt_nx = cnt_q + 1'b1;

    always_comb begin
        if (adv) begin
            cmd_addr = {base_q[AW-1:BURST_BITS], burst_low(base_q[BURST_BITS-1:0], cnt_nx, ilv)};
            cmd_op   = kind_q;
        end else begin
            cmd_addr = ext_addr;
            cmd_op   = ext_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            kind_q <= OP_IDLE;
        end else if (en) begin
            if (adv) begin
                cnt_q <= cnt_nx;
            end else begin
                base_q <= ext_addr;
                cnt_q  <= '0;
                kind_q <= ext_op;
            end
        end
    end
endmodule

// File: rtl/ntd_cmd_pipe.sv
module ntd_cmd_pipe
    import ntd_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  op_e              in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_bwe_n,
    output logic [AW-1:0]    head_addr,
    output op_e              tail_op,
    output logic [AW-1:0]    tail_addr,
    output logic [LANES-1:0] tail_bwe_n
);
    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] bwe_n;
    } slot_t;

    slot_t in_slot;
    assign in_slot = '{op: in_op, addr: in_addr, bwe_n: in_bwe_n};

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        slot_t q;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)     q <= '{op: OP_IDLE, addr: '0, bwe_n: '1};
                else if (en) q <= in_slot;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)     q <= '{op: OP_IDLE, addr: '0, bwe_n: '1};
                else if (en) q <= g_stage[i-1].q;
            end
        end
    end

    assign head_addr  = g_stage[0].q.addr;
    assign tail_op    = g_stage[STAGES-1].q.op;
    assign tail_addr  = g_stage[STAGES-1].q.addr;
    assign tail_bwe_n = g_stage[STAGES-1].q.bwe_n;
endmodule

// File: rtl/ntd_mem_core.sv
module ntd_mem_core
    import ntd_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int WORDS = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (en && op == OP_WRITE && !bwe_n[g])
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            if (en && op == OP_READ)
                q <= cells[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)     rvalid <= 1'b0;
        else if (en) rvalid <= (op == OP_READ);
    end
endmodule

// File: rtl/ntd_sram.sv
module ntd_sram
    import ntd_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    we_n,
    input  logic                    adv,
    input  logic                    burst_ilv,
    input  logic [LANES-1:0]        bwe_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int LATENCY = 2;

    logic              active;
    logic              selected;
    op_e               ext_op;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [ADDR_W-1:0] s1_addr;
    op_e               exec_op;
    logic [ADDR_W-1:0] exec_addr;
    logic [LANES-1:0]  exec_bwe_n;
    logic              rd_valid;

    assign active   = !cke_n;
    assign selected = !ce_a_n && ce_b && !ce_c_n;
    assign ext_op   = !selected ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);

    ntd_burst_ctr #(.AW(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .en       (active),
        .adv      (adv),
        .ilv      (burst_ilv),
        .ext_addr (addr),
        .ext_op   (ext_op),
        .cmd_addr (cmd_addr),
        .cmd_op   (cmd_op)
    );

    ntd_cmd_pipe #(.AW(ADDR_W), .LANES(LANES), .STAGES(LATENCY)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .en         (active),
        .in_op      (cmd_op),
        .in_addr    (cmd_addr),
        .in_bwe_n   (bwe_n),
        .head_addr  (s1_addr),
        .tail_op    (exec_op),
        .tail_addr  (exec_addr),
        .tail_bwe_n (exec_bwe_n)
    );

    ntd_mem_core #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .en     (active),
        .op     (exec_op),
        .addr   (exec_addr),
        .bwe_n  (exec_bwe_n),
        .wdata  (din),
        .rdata  (dout),
        .rvalid (rd_valid)
    );

    assign dout_en = rd_valid && !oe_n;
endmodule

// File: rtl/ntd_sram_chk.sv
module ntd_sram_chk #(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cke_n,
    input logic          ce_a_n,
    input logic          ce_b,
    input logic          ce_c_n,
    input logic          we_n,
    input logic          adv,
    input logic          oe_n,
    input logic [W-1:0]  dout,
    input logic          dout_en,
    input logic          rd_valid,
    input logic [AW-1:0] s1_addr
);
    logic sel_ok;
    assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !dout_en);

    // R4
    read_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && sel_ok && we_n && !cke_n) ##1 !cke_n ##1 !cke_n |=> (dout_en || oe_n));

    // R6
    deselect_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !sel_ok && !cke_n) ##1 !cke_n ##1 !cke_n |=> !dout_en);

    // R7
    burst_page_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !cke_n) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(dout) && $stable(rd_valid)));
endmodule

bind ntd_sram ntd_sram_chk #(.AW(ADDR_W), .W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cke_n    (cke_n),
    .ce_a_n   (ce_a_n),
    .ce_b     (ce_b),
    .ce_c_n   (ce_c_n),
    .we_n     (we_n),
    .adv      (adv),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .rd_valid (rd_valid),
    .s1_addr  (s1_addr)
);

// File: tb/ntd_sram_tb.sv
module ntd_sram_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 8;
    localparam int W     = LANES * LW;
    localparam logic [2:0] SEL = 3'b010; // {ce_a_n, ce_b, ce_c_n} all active

    logic clk = 1'b0;
    logic rst, cke_n, ce_a_n, ce_b, ce_c_n, we_n, adv, burst_ilv, oe_n, dout_en;
    logic [LANES-1:0] bwe_n;
    logic [AW-1:0]    addr;
    logic [W-1:0]     din, dout;

    ntd_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .we_n(we_n), .adv(adv), .burst_ilv(burst_ilv), .bwe_n(bwe_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int               kind; // 0 idle, 1 read, 2 write
        logic [AW-1:0]    a;
        logic [LANES-1:0] bw;
        logic [W-1:0]     wd;
        string            req;
    } op_t;

    typedef struct {
        logic         en;
        logic         rd;
        logic [W-1:0] data;
        string        req;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] model [1<<AW];
    op_t          h1, h2;
    logic [AW-1:0] b_base;
    logic [1:0]   b_cnt;
    int           b_kind;
    int           n_chk = 0;
    int           n_fail = 0;
    logic [W-1:0] last_dout;
    logic         last_en;

    function automatic logic [W-1:0] junk();
        logic [63:0] r = {$urandom, $urandom};
        return r[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One active cycle: drive inputs now, update the reference, then move to the next negedge.
    task automatic issue(input logic adv_i, input logic we_i, input logic [2:0] ce_i,
                         input logic [AW-1:0] a, input logic [LANES-1:0] bw, input logic ilv,
                         input logic oe, input logic [W-1:0] wd, input string req);
        op_t cur;
        exp_t e;
        logic [1:0] lo;
        if (!adv_i) begin
            cur.kind = (ce_i == SEL) ? (we_i ? 1 : 2) : 0;
            cur.a    = a;
            b_base   = a;
            b_cnt    = 2'd0;
            b_kind   = cur.kind;
        end else begin
            b_cnt    = b_cnt + 2'd1;
            lo       = ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
            cur.kind = b_kind;
            cur.a    = {b_base[AW-1:2], lo};
        end
        cur.bw = bw; cur.wd = wd; cur.req = req;
        cke_n = 1'b0; adv = adv_i; we_n = we_i; {ce_a_n, ce_b, ce_c_n} = ce_i;
        addr = a; bwe_n = bw; burst_ilv = ilv; oe_n = oe;
        din = (h2.kind == 2) ? h2.wd : junk();
        if (h2.kind == 2)
            for (int g = 0; g < LANES; g++)
                if (!h2.bw[g]) model[h2.a][g*LW +: LW] = h2.wd[g*LW +: LW];
        e.en = (h2.kind == 1) && !oe;
        e.rd = (h2.kind == 1);
        e.data = model[h2.a];
        e.req = h2.req;
        sb.push_back(e);
        h2 = h1;
        h1 = cur;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] wd, input string req,
                      input logic [LANES-1:0] bw = '0);
        issue(1'b0, 1'b0, SEL, a, bw, 1'b0, 1'b0, wd, req);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        issue(1'b0, 1'b1, SEL, a, '0, 1'b0, 1'b0, junk(), req);
    endtask

    task automatic desel(input logic [2:0] ce_i, input string req, input logic oe = 1'b0);
        issue(1'b0, 1'b1, ce_i, AW'(0), '0, 1'b0, oe, junk(), req);
    endtask

    // Advance: address, we_n and chip enables carry deliberately misleading values.
    task automatic burst(input logic ilv, input logic [W-1:0] wd, input string req);
        issue(1'b1, $urandom_range(0, 1), 3'b101, AW'($urandom), '0, ilv, 1'b0, wd, req);
    endtask

    task automatic stall();
        cke_n = 1'b1; din = junk(); addr = AW'($urandom); we_n = ~we_n; adv = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: one expected item per active edge; stalled edges must leave outputs unchanged.
    initial begin
        forever begin
            logic act;
            exp_t e;
            @(posedge clk);
            act = !cke_n && !rst;
            #(CLK_P/4);
            if (!rst) begin
                if (act) begin
                    if (sb.size() > 0) begin
                        e = sb.pop_front();
                        chk(dout_en === e.en, e.req, "dout_en", W'(dout_en), W'(e.en));
                        if (e.rd) chk(dout === e.data, e.req, "dout", dout, e.data);
                    end
                end else begin
                    // R10: frozen cycle
                    chk(dout === last_dout, "R10", "dout held", dout, last_dout);
                    chk(dout_en === last_en, "R10", "dout_en held", W'(dout_en), W'(last_en));
                end
            end
            last_dout = dout;
            last_en   = dout_en;
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        h1 = '{kind: 0, a: '0, bw: '1, wd: '0, req: "R1"};
        h2 = h1;
        b_base = '0; b_cnt = '0; b_kind = 0;
        rst = 1'b1; cke_n = 1'b0; {ce_a_n, ce_b, ce_c_n} = 3'b100; we_n = 1'b1; adv = 1'b0;
        burst_ilv = 1'b0; bwe_n = '0; oe_n = 1'b0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dout_en === 1'b0, "R1", "dout_en after reset", W'(dout_en), '0);

        // R2 R3: full-word writes, then R4 reads back to back
        for (int i = 0; i < 8; i++) wr(AW'(i), 32'h1000_0000 + i * 32'h0101_0111, "R3");
        wr(AW'(9), 32'hCAFE_0009, "R2");
        for (int i = 0; i < 8; i++) rd(AW'(i), "R4");

        // R12: write then read the same address with no gap
        wr(AW'(9), 32'h1234_5678, "R12");
        rd(AW'(9), "R12");
        wr(AW'(9), 32'h8765_4321, "R12");
        rd(AW'(9), "R12");
        rd(AW'(1), "R12");

        // R5: lanes 0 and 2 written (bwe_n = 4'b1010), lanes 1 and 3 kept
        wr(AW'(3), 32'hAABB_CCDD, "R5", 4'b1010);
        rd(AW'(3), "R5");
        wr(AW'(4), 32'h5566_7788, "R5", 4'b0111);
        rd(AW'(4), "R5");

        // R8: linear write burst from 22 -> 22,23,20,21; linear read burst from 21
        wr(AW'(22), 32'hB000_0016, "R8");
        burst(1'b0, 32'hB000_0017, "R8");
        burst(1'b0, 32'hB000_0014, "R8");
        burst(1'b0, 32'hB000_0015, "R8");
        rd(AW'(21), "R8");
        burst(1'b0, junk(), "R8");
        burst(1'b0, junk(), "R8");
        burst(1'b0, junk(), "R8");

        // R9: interleaved read from 22 -> 22,23,20,21; interleaved write from 29 -> 29,28,31,30
        rd(AW'(22), "R9");
        burst(1'b1, junk(), "R9");
        burst(1'b1, junk(), "R9");
        burst(1'b1, junk(), "R9");
        wr(AW'(29), 32'hC000_001D, "R9");
        burst(1'b1, 32'hC000_001C, "R9");
        burst(1'b1, 32'hC000_001F, "R9");
        burst(1'b1, 32'hC000_001E, "R9");
        for (int i = 28; i < 32; i++) rd(AW'(i), "R9");

        // R7: advance after a deselect stays deselected
        desel(3'b000, "R7");
        burst(1'b0, junk(), "R7");
        burst(1'b1, junk(), "R7");

        // R6: each chip enable alone deselects; an accepted read still completes
        rd(AW'(0), "R6");
        desel(3'b110, "R6");
        desel(3'b011, "R6");
        wr(AW'(2), 32'hD00D_0002, "R6");
        desel(3'b000, "R6");
        desel(3'b110, "R6");
        rd(AW'(2), "R6");

        // R10: stalls between a write command and its data slot
        wr(AW'(40), 32'hE000_0028, "R10");
        stall();
        stall();
        desel(3'b110, "R10");
        stall();
        desel(3'b110, "R10");
        rd(AW'(40), "R10");
        rd(AW'(5), "R10");
        desel(3'b110, "R10");
        stall();
        stall();
        desel(3'b110, "R10");

        // R11: output enable high hides the read but the data is still loaded
        rd(AW'(5), "R11");
        desel(3'b110, "R11", 1'b1);
        desel(3'b110, "R11", 1'b1);
        rd(AW'(6), "R11");
        desel(3'b110, "R11");
        desel(3'b110, "R11");

        // drain
        desel(3'b110, "R6");
        desel(3'b110, "R6");
        @(negedge clk);
        chk(sb.size() == 0, "R4", "scoreboard drained", W'(sb.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule